// File: doc/BRIEF.md
# Two-Stage Reset Release Sequencer

This block turns one active-low power-on reset pin into two internal resets, one for a crystal-rate clock domain and one for a peripheral clock domain. It also drives a 2-bit status output that tells the outside world whether the device is held in reset or running. Pulling the pin low resets everything at once, with no clock needed. Releasing the pin starts a two-stage hold. First a fixed number of crystal clocks is counted. The result of that count is then passed to the peripheral domain, where a fixed number of peripheral clocks is counted before the peripheral reset is released.

The crystal-domain reset is released last. It follows the peripheral release back through a synchronizer, so logic on the crystal clock never runs while peripheral logic is still held. The status output is set to its reset code at once by the pin. It only returns to the run code on a peripheral clock edge, so it has no timing relation to the crystal clock. A low pulse on the pin at any point in the sequence clears both hold counts, and the next release takes the full time again.

Top module: `rstseq_top`

## Requirements
- R1: While `por_n_i` is low, including at power-up, `prst_n_o` and `xrst_n_o` are 0 and `status_o` is 2'b11 (reset code).
- R2: A falling `por_n_i` forces `prst_n_o`=0, `xrst_n_o`=0 and `status_o`=2'b11 immediately, without waiting for any clock edge.
- R3: The rising pin is synchronized into the crystal domain through SYNC_STAGES (default 2) flops. The crystal stage then completes on the XTAL_HOLD-th (default 20) crystal edge after the synchronizer output is high, that is on the 22nd crystal edge after the pin rises.
- R4: Completion of the crystal stage is a level that crosses into the peripheral domain through SYNC_STAGES flops. `prst_n_o` rises on the PCLK_HOLD-th (default 45) peripheral edge at which the crossed level is seen high.
- R5: `status_o` only ever takes the values 2'b11 or 2'b00. It changes to 2'b00 on the first peripheral edge after `prst_n_o` is high, and it stays 2'b11 for as long as `prst_n_o` is low.
- R6: `xrst_n_o` rises after the peripheral release has passed through SYNC_STAGES crystal flops, and it is never high while `prst_n_o` is low.
- R7: If the pin falls at any point in the sequence, both hold counts restart from zero. The next release takes the full two-stage time, measured from the last rising edge of the pin.
- R8: `prst_n_o` is never high before the crystal-stage hold has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xclk_i | input | 1 | Crystal-rate clock |
| pclk_i | input | 1 | Peripheral clock |
| por_n_i | input | 1 | External power-on reset pin, active low |
| xrst_n_o | output | 1 | Crystal-domain reset, active low |
| prst_n_o | output | 1 | Peripheral-domain reset, active low |
| status_o | output | 2 | 2'b11 means in reset, 2'b00 means normal operation |

## Verification
Every cycle, the assertions check the following:
- the status output only takes its two legal codes, and it follows the peripheral release one edge later;
- the peripheral release never happens before the crystal stage has completed, and the crystal reset never releases ahead of the peripheral reset;
- neither hold counter passes its terminal value, and a counter stays done once it is done.

The exact release edges, the immediate effect of a falling pin, and the full restart after the pin is pulled low partway through either stage can only be shown by the bench scenarios. There, a reference model is compared with the outputs on every peripheral clock, and the release time is measured against bounds.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [1:0] {
      RSQ_ST_RUN   = 2'b00,
      RSQ_ST_RESET = 2'b11
   } rsq_status_e;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-flop synchronizer: clears asynchronously, shifts d_i in on clk_i.
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) chain_q <= '0;
      else           chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_hold_cnt.sv
// Counts enabled edges; done_o rises on the HOLD-th enabled edge and sticks.
module rstseq_hold_cnt #(
   parameter int HOLD = 20
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic en_i,
   output logic done_o
);

   localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("rstseq_hold_cnt: HOLD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (en_i && !done_q) begin
         if (cnt_q == LAST) done_q <= 1'b1;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign done_o = done_q;

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cnt_q <= LAST);                                          // R3
   AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_q |=> done_q);                                      // R4

endmodule

// File: rtl/rstseq_status.sv
// Status flop: preset to the reset code by the pin, released on the peripheral clock.
module rstseq_status
   import rstseq_pkg::*;
(
   input  logic       clk_i,
   input  logic       por_n_i,
   input  logic       run_i,
   output logic [1:0] status_o
);

   rsq_status_e st_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) st_q <= RSQ_ST_RESET;
      else          st_q <= run_i ? RSQ_ST_RUN : RSQ_ST_RESET;
   end

   assign status_o = st_q;

   AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (status_o == RSQ_ST_RUN) || (status_o == RSQ_ST_RESET)); // R5
   AST_STATUS_FOLLOW: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(run_i) |=> (status_o == RSQ_ST_RUN));              // R5

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int XTAL_HOLD   = 20,
   parameter int PCLK_HOLD   = 45
) (
   input  logic       xclk_i,
   input  logic       pclk_i,
   input  logic       por_n_i,
   output logic       xrst_n_o,
   output logic       prst_n_o,
   output logic [1:0] status_o
);

   generate
      if (XTAL_HOLD < 2 || PCLK_HOLD < 2) begin : g_bad_hold
         $error("rstseq_top: hold counts must be at least 2");
      end
   endgenerate

   logic x_rel;      // pin release seen in crystal domain
   logic x_done;     // crystal hold complete
   logic p_rel;      // pin release seen in peripheral domain
   logic x_done_p;   // crystal completion crossed to peripheral domain
   logic p_done;     // peripheral hold complete
   logic p_done_x;   // peripheral completion crossed back to crystal domain

   rstseq_sync #(.STAGES(SYNC_STAGES)) i_xpin_sync (
      .clk_i(xclk_i), .arst_n_i(por_n_i), .d_i(1'b1), .q_o(x_rel));

   rstseq_hold_cnt #(.HOLD(XTAL_HOLD)) i_xhold (
      .clk_i(xclk_i), .rst_n_i(x_rel), .en_i(1'b1), .done_o(x_done));

   rstseq_sync #(.STAGES(SYNC_STAGES)) i_ppin_sync (
      .clk_i(pclk_i), .arst_n_i(por_n_i), .d_i(1'b1), .q_o(p_rel));

   rstseq_sync #(.STAGES(SYNC_STAGES)) i_handoff (
      .clk_i(pclk_i), .arst_n_i(p_rel), .d_i(x_done), .q_o(x_done_p));

   rstseq_hold_cnt #(.HOLD(PCLK_HOLD)) i_phold (
      .clk_i(pclk_i), .rst_n_i(p_rel), .en_i(x_done_p), .done_o(p_done));

   rstseq_sync #(.STAGES(SYNC_STAGES)) i_backsync (
      .clk_i(xclk_i), .arst_n_i(x_rel), .d_i(p_done), .q_o(p_done_x));

   rstseq_status i_status (
      .clk_i(pclk_i), .por_n_i(por_n_i), .run_i(p_done), .status_o(status_o));

   assign prst_n_o = p_done;
   assign xrst_n_o = p_done_x;

   AST_PRST_NEEDS_XDONE: assert property (@(posedge pclk_i) disable iff (!por_n_i)
      prst_n_o |-> x_done);                                    // R8
   AST_XRST_AFTER_PRST: assert property (@(posedge xclk_i) disable iff (!por_n_i)
      xrst_n_o |-> prst_n_o);                                  // R6
   AST_STATUS_HELD: assert property (@(posedge pclk_i) disable iff (!por_n_i)
      !prst_n_o |=> (status_o == RSQ_ST_RESET));               // R5

endmodule

// File: tb/test_rstseq_top.sv
module test_rstseq_top;

   localparam int SYNC = 2;
   localparam int XH   = 20;
   localparam int PH   = 45;
   localparam int PP   = 20;   // peripheral period, 50 MHz
   localparam int XP   = 26;   // crystal period

   logic xclk, pclk, por_n;
   logic xrst_n, prst_n;
   logic [1:0] status;

   int n_chk  = 0;
   int n_fail = 0;
   bit cmp_on = 0;

   rstseq_top #(.SYNC_STAGES(SYNC), .XTAL_HOLD(XH), .PCLK_HOLD(PH)) i_rstseq_top (
      .xclk_i(xclk), .pclk_i(pclk), .por_n_i(por_n),
      .xrst_n_o(xrst_n), .prst_n_o(prst_n), .status_o(status));

   // crystal posedges at odd times, peripheral posedges at even times: never coincide
   initial begin xclk = 0; #3; forever begin xclk = 1; #13; xclk = 0; #13; end end
   initial begin pclk = 0; #10; forever begin pclk = 1; #10; pclk = 0; #10; end end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_xs = 0, m_xcnt = 0, m_xr1 = 0, m_xr2 = 0;
   int m_ps = 0, m_h1 = 0, m_h2 = 0, m_pcnt = 0, m_pdone = 0, m_st = 3;

   always @(posedge xclk) begin
      if (!por_n) begin
         m_xs = 0; m_xcnt = 0; m_xr1 = 0; m_xr2 = 0;
      end else begin
         if (m_xs >= SYNC) begin
            if (m_xcnt < XH) m_xcnt++;
            m_xr2 = m_xr1;
            m_xr1 = m_pdone;
         end
         if (m_xs < SYNC) m_xs++;
      end
   end

   always @(posedge pclk) begin
      if (!por_n) begin
         m_ps = 0; m_h1 = 0; m_h2 = 0; m_pcnt = 0; m_pdone = 0; m_st = 3;
      end else begin
         m_st = (m_pdone != 0) ? 0 : 3;
         if (m_ps >= SYNC) begin
            if (m_h2 != 0 && m_pcnt < PH) m_pcnt++;
            m_h2 = m_h1;
            m_h1 = (m_xcnt >= XH) ? 1 : 0;
         end
         m_pdone = (m_pcnt >= PH) ? 1 : 0;
         if (m_ps < SYNC) m_ps++;
      end
   end

   always @(negedge pclk) begin
      if (cmp_on) begin
         int e_p, e_x, e_s;
         e_p = por_n ? m_pdone : 0;
         e_x = por_n ? m_xr2   : 0;
         e_s = por_n ? m_st    : 3;
         chk(int'(prst_n) == e_p, "R4 prst_n_o vs model", int'(prst_n), e_p);
         chk(int'(status) == e_s, "R5 status_o vs model", int'(status), e_s);
         chk(int'(xrst_n) == e_x, "R6 xrst_n_o vs model", int'(xrst_n), e_x);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic pin_low(input int hold);
      @(negedge pclk); #2; por_n = 0;
      #1;
      chk(prst_n == 1'b0, "R2 async prst_n_o", int'(prst_n), 0);
      chk(xrst_n == 1'b0, "R2 async xrst_n_o", int'(xrst_n), 0);
      chk(status == 2'b11, "R2 async status_o", int'(status), 3);
      repeat (hold) @(negedge pclk);
   endtask

   task automatic release_measure(input string req);
      time t0;
      int  dt;
      bit  seen;
      seen = 0;
      @(negedge pclk); #2; por_n = 1; t0 = $time;
      for (int i = 0; i < 200 && !seen; i++) begin
         @(negedge pclk);
         if (prst_n) seen = 1;
      end
      dt = int'($time - t0);
      chk(seen, {req, " release seen"}, int'(seen), 1);
      chk(dt >= 21*XP + (PH+1)*PP, {req, " R3 R8 not early"}, dt, 21*XP + (PH+1)*PP);
      chk(dt <= 22*XP + (PH+3)*PP, {req, " R4 not late"}, dt, 22*XP + (PH+3)*PP);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * PP);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      por_n = 0;
      repeat (8) @(negedge pclk);
      // R1 power-up state
      chk(prst_n == 1'b0, "R1 prst_n_o at power-up", int'(prst_n), 0);
      chk(xrst_n == 1'b0, "R1 xrst_n_o at power-up", int'(xrst_n), 0);
      chk(status == 2'b11, "R1 status_o at power-up", int'(status), 3);
      cmp_on = 1;

      // clean release
      release_measure("first");
      repeat (10) @(negedge pclk);
      chk(status == 2'b00, "R5 status run code", int'(status), 0);
      chk(xrst_n == 1'b1, "R6 crystal reset released", int'(xrst_n), 1);

      // reset while running
      pin_low(6);
      chk(status == 2'b11, "R1 status held low pin", int'(status), 3);

      // abort inside crystal stage
      @(negedge pclk); #2; por_n = 1;
      repeat (12) @(negedge pclk);
      chk(prst_n == 1'b0, "R8 no release mid crystal stage", int'(prst_n), 0);
      pin_low(5);
      release_measure("R7 after crystal-stage abort");

      // abort inside peripheral stage
      pin_low(5);
      @(negedge pclk); #2; por_n = 1;
      repeat (50) @(negedge pclk);
      chk(prst_n == 1'b0, "R4 still held in peripheral stage", int'(prst_n), 0);
      pin_low(5);
      release_measure("R7 after peripheral-stage abort");
      repeat (10) @(negedge pclk);
      chk(xrst_n == 1'b1, "R6 crystal reset released again", int'(xrst_n), 1);

      cmp_on = 0;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule